// File: doc/BRIEF.md
# Multi-format serial PCM audio receiver

This block takes stereo PCM audio from a three-wire serial link: a bit clock, a frame clock that toggles once per channel half and a serial data line. All three lines are brought into the system clock domain through a synchronizer. The rising edges of the bit clock are found by oversampling, and each edge samples one data bit. A slot counter that restarts at every frame-clock transition finds where the sample lies inside each half.

Four framing modes are supported: right-justified 16-bit and 18-bit at 64 bit clocks per frame, I2S-style 18-bit at 64 bit clocks per frame, and I2S-style 16-bit at 32 bit clocks per frame. Output words are always 18 bits wide, and 16-bit samples are sign-extended. When the right sample of a frame completes a left/right pair, both words are presented together with a one-cycle strobe.

Top module: `pcm_serial_rx`

## Requirements
- R1: While reset is held and right after it, `valid_o` is 0 and both output words are 0.
- R2: Data is taken on bit-clock rising edges and arrives MSB first. Slot 0 of a half is the first rising edge that sees the new frame-clock level.
- R3: Mode 0 (right-justified, 16-bit, 32 slots per half): the sample occupies slots 16..31, with the MSB in slot 16 and the LSB in slot 31.
- R4: Mode 1 (right-justified, 18-bit, 32 slots per half): the sample occupies slots 14..31, with the MSB in slot 14.
- R5: Mode 2 (I2S, 18-bit, 32 slots per half): the MSB is in slot 1 and the LSB in slot 18.
- R6: Mode 3 (I2S, 16-bit, 16 slots per half): bits 15..1 are in slots 1..15, and bit 0 is in slot 0 of the following half.
- R7: In modes 0 and 1 a high frame clock marks the left channel. In modes 2 and 3 a low frame clock marks the left channel.
- R8: `valid_o` pulses for exactly one cycle after a right sample is captured, and only if a left sample was captured in the half before it. The output words change only in that cycle.
- R9: In modes 0 and 3, output bits 17 and 16 equal bit 15.
- R10: A new value on `fmt_sel_i` takes effect at the next frame-clock transition. The half in progress is still decoded in the old mode.
- R11: Bits in slots outside the sample field have no effect on the output words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| bck_i | input | 1 | Serial bit clock |
| fck_i | input | 1 | Frame (left/right) clock |
| sd_i | input | 1 | Serial data |
| fmt_sel_i | input | 2 | Framing mode: 0 RJ16, 1 RJ18, 2 I2S18, 3 I2S16 |
| left_o | output | 18 | Left sample, sign-extended for 16-bit modes |
| right_o | output | 18 | Right sample, sign-extended for 16-bit modes |
| valid_o | output | 1 | One-cycle strobe when a left/right pair is presented |

## Verification
The hardest cases to reach are the I2S 16-bit mode, where the right word is completed only by slot 0 of the next frame's left half, and a format change written in the middle of a half. For the first case, each stream ends with a trailing half that carries the pending LSB. For the second, the mode pin is switched a few slots into the last right half of a right-justified 16-bit run, and the bench expects that half to still decode as 16-bit. Every don't-care slot carries random bits, so a field that is misplaced or reaches too far shows up as a miscompare.

// File: rtl/pcmrx_pkg.sv
package pcmrx_pkg;

   typedef enum logic [1:0] {
      FMT_RJ_NARROW  = 2'd0,
      FMT_RJ_WIDE    = 2'd1,
      FMT_I2S_WIDE   = 2'd2,
      FMT_I2S_NARROW = 2'd3
   } fmt_e;

   // I2S-style framing: MSB one slot after the frame-clock edge, left = low
   function automatic logic fmt_is_i2s(fmt_e f);
      return (f == FMT_I2S_WIDE) || (f == FMT_I2S_NARROW);
   endfunction

   // 16-bit sample formats need sign extension
   function automatic logic fmt_is_narrow(fmt_e f);
      return (f == FMT_RJ_NARROW) || (f == FMT_I2S_NARROW);
   endfunction

endpackage

// File: rtl/pcmrx_sync.sv
module pcmrx_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pcmrx_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("pcmrx_sync: WIDTH must be positive");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pcmrx_slot.sv
module pcmrx_slot
   import pcmrx_pkg::*;
#(
   parameter int SAMPLE_W   = 18,
   parameter int NARROW_W   = 16,
   parameter int HALF_SLOTS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bck_s,
   input  logic                fck_s,
   input  logic                sd_s,
   input  fmt_e                fmt_i,
   output logic                cap_o,
   output logic                cap_left_o,
   output logic [SAMPLE_W-1:0] cap_word_o
);

   localparam int CNT_W = $clog2(HALF_SLOTS) + 1;
   localparam int EXT_W = SAMPLE_W - NARROW_W;
   localparam logic [CNT_W-1:0] SLOT_SAT        = '1;
   localparam logic [CNT_W-1:0] SLOT_ONE        = CNT_W'(1);
   localparam logic [CNT_W-1:0] SLOT_RJ_LAST    = CNT_W'(HALF_SLOTS - 1);
   localparam logic [CNT_W-1:0] SLOT_I2SW_LAST  = CNT_W'(SAMPLE_W);
   localparam logic [CNT_W-1:0] SLOT_I2SN_LAST  = CNT_W'(NARROW_W - 1);

   if (NARROW_W >= SAMPLE_W) begin : g_bad_narrow
      $error("pcmrx_slot: NARROW_W must be below SAMPLE_W");
   end
   if (SAMPLE_W + 1 > HALF_SLOTS) begin : g_bad_half
      $error("pcmrx_slot: an I2S wide sample must fit after slot 0");
   end

   logic                bck_d;
   logic                fck_q;
   logic [CNT_W-1:0]    slot_q, slot_nxt;
   fmt_e                mode_q;
   logic [SAMPLE_W-1:0] sh_q, sh_nxt;
   logic                bit_edge, trans;
   logic                hit, hit_lvl;
   logic                mode_i2s, mode_narrow;
   logic [SAMPLE_W-1:0] word_ext;
   logic                cap_narrow_q;
   fmt_e                cap_mode_q;

   always_comb begin
      bit_edge    = bck_s & ~bck_d;
      trans       = bit_edge && (fck_s != fck_q);
      sh_nxt      = {sh_q[SAMPLE_W-2:0], sd_s};
      mode_i2s    = fmt_is_i2s(mode_q);
      mode_narrow = fmt_is_narrow(mode_q);
      if (trans)                  slot_nxt = '0;
      else if (slot_q == SLOT_SAT) slot_nxt = SLOT_SAT;
      else                        slot_nxt = slot_q + SLOT_ONE;
      hit_lvl = fck_q;
      hit     = 1'b0;
      if (bit_edge) begin
         if (trans) begin
            // narrow I2S: LSB rides in slot 0 of the next half
            hit = (mode_q == FMT_I2S_NARROW) && (slot_q == SLOT_I2SN_LAST);
         end else begin
            case (mode_q)
               FMT_RJ_NARROW, FMT_RJ_WIDE: hit = (slot_nxt == SLOT_RJ_LAST);
               FMT_I2S_WIDE:               hit = (slot_nxt == SLOT_I2SW_LAST);
               default:                    hit = 1'b0;
            endcase
         end
      end
      if (mode_narrow)
         word_ext = {{EXT_W{sh_nxt[NARROW_W-1]}}, sh_nxt[NARROW_W-1:0]};
      else
         word_ext = sh_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bck_d        <= 1'b0;
         fck_q        <= 1'b0;
         slot_q       <= SLOT_SAT;
         mode_q       <= FMT_RJ_NARROW;
         sh_q         <= '0;
         cap_o        <= 1'b0;
         cap_left_o   <= 1'b0;
         cap_word_o   <= '0;
         cap_narrow_q <= 1'b0;
         cap_mode_q   <= FMT_RJ_NARROW;
      end else begin
         bck_d <= bck_s;
         if (bit_edge) begin
            fck_q  <= fck_s;
            slot_q <= slot_nxt;
            sh_q   <= sh_nxt;
            if (trans) mode_q <= fmt_i;
         end
         cap_o <= hit;
         if (hit) begin
            cap_left_o   <= mode_i2s ? ~hit_lvl : hit_lvl;
            cap_word_o   <= word_ext;
            cap_narrow_q <= mode_narrow;
            cap_mode_q   <= mode_q;
         end
      end
   end

   // R10: the active format moves only on a frame-clock transition
   a_r10_mode_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !trans |=> $stable(mode_q));

   // R9: 16-bit captures carry their sign into the upper bits
   a_r9_sign_ext : assert property (@(posedge clk) disable iff (!rst_n)
      (cap_o && cap_narrow_q) |->
         (cap_word_o[SAMPLE_W-1:NARROW_W] == {EXT_W{cap_word_o[NARROW_W-1]}}));

   // R5: wide I2S words complete exactly in slot SAMPLE_W
   a_r5_i2s_wide_slot : assert property (@(posedge clk) disable iff (!rst_n)
      (cap_o && cap_mode_q == FMT_I2S_WIDE) |-> (slot_q == SLOT_I2SW_LAST));

endmodule

// File: rtl/pcmrx_pair.sv
module pcmrx_pair #(
   parameter int SAMPLE_W = 18
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cap_i,
   input  logic                cap_left_i,
   input  logic [SAMPLE_W-1:0] cap_word_i,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic                valid_o
);

   if (SAMPLE_W < 2) begin : g_bad_w
      $error("pcmrx_pair: SAMPLE_W too small");
   end

   logic                have_left_q;
   logic [SAMPLE_W-1:0] left_hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_left_q <= 1'b0;
         left_hold_q <= '0;
         left_o      <= '0;
         right_o     <= '0;
         valid_o     <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (cap_i) begin
            if (cap_left_i) begin
               left_hold_q <= cap_word_i;
               have_left_q <= 1'b1;
            end else begin
               have_left_q <= 1'b0;
               if (have_left_q) begin
                  left_o  <= left_hold_q;
                  right_o <= cap_word_i;
                  valid_o <= 1'b1;
               end
            end
         end
      end
   end

   // R8: strobe lasts one cycle
   a_r8_single_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R8: words hold between strobes
   a_r8_words_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> ($stable(left_o) && $stable(right_o)));

endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
   import pcmrx_pkg::*;
#(
   parameter int SAMPLE_W    = 18,
   parameter int NARROW_W    = 16,
   parameter int HALF_SLOTS  = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bck_i,
   input  logic                fck_i,
   input  logic                sd_i,
   input  logic [1:0]          fmt_sel_i,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic                valid_o
);

   localparam int LINES = 3;

   logic [LINES-1:0]    lines_s;
   logic                cap;
   logic                cap_left;
   logic [SAMPLE_W-1:0] cap_word;

   pcmrx_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({bck_i, fck_i, sd_i}),
      .q_o   (lines_s)
   );

   pcmrx_slot #(
      .SAMPLE_W   (SAMPLE_W),
      .NARROW_W   (NARROW_W),
      .HALF_SLOTS (HALF_SLOTS)
   ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .bck_s      (lines_s[2]),
      .fck_s      (lines_s[1]),
      .sd_s       (lines_s[0]),
      .fmt_i      (fmt_e'(fmt_sel_i)),
      .cap_o      (cap),
      .cap_left_o (cap_left),
      .cap_word_o (cap_word)
   );

   pcmrx_pair #(.SAMPLE_W(SAMPLE_W)) u_pair (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap_i      (cap),
      .cap_left_i (cap_left),
      .cap_word_i (cap_word),
      .left_o     (left_o),
      .right_o    (right_o),
      .valid_o    (valid_o)
   );

endmodule

// File: tb/pcm_serial_rx_bench.sv
module pcm_serial_rx_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bck_i = 1'b0;
   logic        fck_i = 1'b0;
   logic        sd_i = 1'b0;
   logic [1:0]  fmt_sel_i = 2'd0;
   logic [17:0] left_o, right_o;
   logic        valid_o;

   int   n_checks = 0;
   int   n_fail   = 0;
   bit   done     = 1'b0;
   logic prev_lsb = 1'b0;
   string cur_tag = "R3";
   logic [35:0] exp_q[$];

   always #4 clk = ~clk;

   pcm_serial_rx u_pcm_serial_rx (
      .clk(clk), .rst_n(rst_n), .bck_i(bck_i), .fck_i(fck_i), .sd_i(sd_i),
      .fmt_sel_i(fmt_sel_i), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
   );

   function automatic logic [17:0] ext(input logic [1:0] m, input logic [17:0] w);
      // R9: 16-bit modes 0 and 3 sign-extend bit 15
      if (m == 2'd0 || m == 2'd3) return {{2{w[15]}}, w[15:0]};
      return w;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // R2: new bit and frame level set while bit clock is low, taken at its rise
   task automatic drive_slot(input logic lvl, input logic b);
      bck_i = 1'b0; fck_i = lvl; sd_i = b;
      repeat (4) @(negedge clk);
      bck_i = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   // R11: every slot outside the field carries random junk
   task automatic send_half(input logic [1:0] m, input logic lvl, input logic [17:0] w,
                            input int sw_slot, input logic [1:0] sw_fmt);
      int n;
      n = (m == 2'd3) ? 16 : 32;
      for (int s = 0; s < n; s++) begin
         logic b;
         b = 1'($urandom % 2);
         case (m)
            2'd0: if (s >= 16) b = w[31-s];             // R3
            2'd1: if (s >= 14) b = w[31-s];             // R4
            2'd2: if (s >= 1 && s <= 18) b = w[18-s];   // R5
            default: b = (s == 0) ? prev_lsb : w[16-s]; // R6
         endcase
         if (s == sw_slot) fmt_sel_i = sw_fmt;
         drive_slot(lvl, b);
      end
      prev_lsb = w[0];
   endtask

   // R7: left level high in modes 0/1, low in modes 2/3
   function automatic logic left_lvl(input logic [1:0] m);
      return (m >= 2'd2) ? 1'b0 : 1'b1;
   endfunction

   task automatic send_frame(input logic [1:0] m, input logic [17:0] l, input logic [17:0] r,
                             input int sw_slot, input logic [1:0] sw_fmt);
      exp_q.push_back({ext(m, l), ext(m, r)});
      send_half(m, left_lvl(m), l, -1, 2'd0);
      send_half(m, ~left_lvl(m), r, sw_slot, sw_fmt);
   endtask

   task automatic do_reset(input logic [1:0] m);
      rst_n = 1'b0; bck_i = 1'b0; fck_i = 1'b0; sd_i = 1'b0; fmt_sel_i = m;
      repeat (4) @(negedge clk);
      // R1: outputs idle under reset
      check(valid_o == 1'b0 && left_o == '0 && right_o == '0, "R1 reset",
            {left_o, right_o}, 36'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(valid_o == 1'b0 && left_o == '0 && right_o == '0, "R1 after reset",
            {left_o, right_o}, 36'd0);
   endtask

   function automatic logic [17:0] pick(input int i);
      case (i)
         0: return 18'h00000;
         1: return 18'h3FFFF;
         2: return 18'h1FFFF;
         3: return 18'h20000;
         4: return 18'h08000;
         5: return 18'h07FFF;
         6: return 18'h2AAAA;
         7: return 18'h15555;
         default: return 18'($urandom);
      endcase
   endfunction

   task automatic finish_segment(input logic [1:0] m, input string tag);
      // trailing left half: flushes the narrow I2S LSB, yields no pair
      send_half(m, left_lvl(m), 18'($urandom), -1, 2'd0);
      repeat (20) @(negedge clk);
      // R8: every sent frame produced exactly one strobe
      check(exp_q.size() == 0, {tag, " R8 pending pairs"}, 36'(exp_q.size()), 36'd0);
      exp_q.delete();
   endtask

   task automatic run_mode(input logic [1:0] m, input string tag, input int nfr);
      cur_tag = tag;
      do_reset(m);
      // leading right half: a right word with no left must not strobe (R8)
      send_half(m, ~left_lvl(m), 18'($urandom), -1, 2'd0);
      for (int i = 0; i < nfr; i++) send_frame(m, pick(i), pick(nfr - 1 - i), -1, 2'd0);
      finish_segment(m, tag);
   endtask

   // monitor: compare each strobed pair against the expected queue
   initial begin
      forever begin
         @(negedge clk);
         if (valid_o) begin
            if (exp_q.size() == 0) begin
               check(1'b0, {cur_tag, " R8 unexpected strobe"}, {left_o, right_o}, 36'd0);
            end else begin
               logic [35:0] e;
               e = exp_q.pop_front();
               check({left_o, right_o} == e, {cur_tag, " R7 R9 R11 pair"}, {left_o, right_o}, e);
            end
         end
      end
   end

   initial begin
      run_mode(2'd0, "R3", 10);
      run_mode(2'd1, "R4", 10);
      run_mode(2'd2, "R5", 10);
      run_mode(2'd3, "R6", 10);
      // R10: pin switches to mode 1 five slots into the last mode-0 right half
      cur_tag = "R10";
      do_reset(2'd0);
      send_half(2'd0, 1'b0, 18'($urandom), -1, 2'd0);
      send_frame(2'd0, 18'h0C001, 18'h3F0F0, -1, 2'd0);
      send_frame(2'd0, 18'h3B7FF, 18'h00123, -1, 2'd0);
      send_frame(2'd0, 18'h2FFFF, 18'h18000, 5, 2'd1);
      send_frame(2'd1, 18'h2ABCD, 18'h1FFFE, -1, 2'd0);
      send_frame(2'd1, 18'h30000, 18'h0FFFF, -1, 2'd0);
      send_frame(2'd1, 18'h00001, 18'h3FFFF, -1, 2'd0);
      finish_segment(2'd1, "R10");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

endmodule